// File: doc/BRIEF.md
# Six-State Single-Step Sequence Counter

This block is a 3-bit synchronous counter that does not count in binary. While its enable input is high it moves through a closed loop of six codes, 0 → 1 → 3 → 7 → 6 → 4, and then back to 0. Between any two neighbouring codes in this loop exactly one bit differs, so a decoder placed on the state never sees a multi-bit glitch. When enable is low, the state holds.

Each state bit is updated in the manner of a J-K flip-flop. A J and a K term are formed from the present code, and the bit then holds, sets, clears or toggles. The logic is written behaviourally around one shared clock.

Codes 2 and 5 are not part of the loop. If the register ever holds one of them, the next clock returns it to 0, whether or not enable is high. A registered wrap pulse marks each completion of the loop. The reset is synchronous, active high, and takes priority over everything else.

Top module: `seq6_counter`

## Requirements
- R1: While `syncReset` is high at a rising clock edge, `countState` becomes 0 and `wrapPulse` becomes 0 after that edge.
- R2: With `syncReset` low and `enable` high, each rising edge moves `countState` (a plain binary value) to the next code in the cyclic order 0, 1, 3, 7, 6, 4, 0.
- R3: With `syncReset` low and `enable` low, a legal `countState` keeps its value across the edge, and `wrapPulse` is 0 after it.
- R4: `wrapPulse` is 1 for exactly the one cycle that follows an enabled step from code 4 to code 0, and is 0 in every other cycle.
- R5: Every enabled step from a legal code changes exactly one bit of `countState`.
- R6: If `countState` holds 2 or 5 and `syncReset` is low, the next edge loads 0, whatever the level of `enable`, and `wrapPulse` stays 0.
- R7: When `syncReset` and `enable` are both high, the reset wins and `countState` becomes 0.
- R8: Starting from reset, `countState` never shows code 2 or code 5 under any pattern of `enable` and `syncReset`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock shared by all state bits |
| syncReset | input | 1 | Synchronous, active-high reset to code 0 |
| enable | input | 1 | Count enable; the state holds when it is low |
| countState | output | 3 | Present code of the counter |
| wrapPulse | output | 1 | One-cycle pulse after the step from 4 to 0 |

## Verification
The embedded assertions check on every clock that reset forces code 0, that a held or enabled step from a legal code moves either zero bits or exactly one bit as required, that an unused code is always followed by 0, and that the wrap pulse only ever coincides with code 0. Only the bench's scenarios can show the full cyclic order and the exact cycle on which the wrap pulse occurs, because the reference model tracks the position in the loop. The same applies to reset winning over enable in the middle of the loop, and to recovery from codes 2 and 5, which the bench places into the state register directly.

// File: rtl/seq6_counter_pkg.sv
package seq6_counter_pkg;

  localparam int STATE_W = 3;

  typedef logic [STATE_W-1:0] code_t;

  localparam code_t START_CODE = code_t'(0);
  localparam code_t LAST_CODE  = code_t'(4);
  localparam code_t HOLE_LO    = code_t'(2);
  localparam code_t HOLE_HI    = code_t'(5);

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // synchronous reset
    logic advance;  // take one step along the loop
    logic recover;  // force an unused code back to start
  } strobe_t;

  function automatic logic isUnused(input code_t c);
    return (c == HOLE_LO) || (c == HOLE_HI);
  endfunction

endpackage

// File: rtl/seq6_counter_ctrl.sv
module seq6_counter_ctrl
  import seq6_counter_pkg::*;
(
  input  logic    syncReset,
  input  logic    enable,
  input  code_t   stateQ,
  output strobe_t strobes
);

  logic unusedNow;

  always_comb begin
    unusedNow       = isUnused(stateQ);
    strobes.clear   = syncReset;
    strobes.recover = !syncReset && unusedNow;
    strobes.advance = !syncReset && enable && !unusedNow;
  end

endmodule

// File: rtl/seq6_counter_dpath.sv
module seq6_counter_dpath
  import seq6_counter_pkg::*;
(
  input  logic    clk,
  input  strobe_t strobes,
  output code_t   stateQ,
  output logic    wrapQ
);

  code_t jTerm;
  code_t kTerm;
  code_t jkNext;
  code_t nextCode;

  // J/K excitation for the loop 0,1,3,7,6,4
  always_comb begin
    jTerm[0] = ~stateQ[2];
    kTerm[0] =  stateQ[2];
    jTerm[1] =  stateQ[0];
    kTerm[1] = ~stateQ[0];
    jTerm[2] =  stateQ[1];
    kTerm[2] = ~stateQ[1];
  end

  // Characteristic equation applied bit by bit
  for (genvar b = 0; b < STATE_W; b++) begin : g_jkBit
    assign jkNext[b] = (jTerm[b] & ~stateQ[b]) | (~kTerm[b] & stateQ[b]);
  end

  always_comb begin
    if (strobes.clear || strobes.recover) begin
      nextCode = START_CODE;
    end else if (strobes.advance) begin
      nextCode = jkNext;
    end else begin
      nextCode = stateQ;
    end
  end

  always_ff @(posedge clk) begin
    stateQ <= nextCode;
    wrapQ  <= !strobes.clear && strobes.advance && (stateQ == LAST_CODE);
  end

  // R1: reset lands on the start code
  assert_reset_start_R1: assert property (@(posedge clk)
    strobes.clear |=> (stateQ == START_CODE) && !wrapQ);

  // R5: legal enabled step flips exactly one bit
  assert_single_flip_R5: assert property (@(posedge clk) disable iff (strobes.clear)
    (!isUnused(stateQ) && $past(strobes.advance) && !$past(isUnused(stateQ)))
      |-> ($countones(stateQ ^ $past(stateQ)) == 1));

  // R6: unused code recovers in one edge
  assert_hole_recover_R6: assert property (@(posedge clk) disable iff (strobes.clear)
    isUnused(stateQ) |=> (stateQ == START_CODE) && !wrapQ);

  // R4: wrap only coincides with start code
  assert_wrap_at_start_R4: assert property (@(posedge clk) disable iff (strobes.clear)
    wrapQ |-> (stateQ == START_CODE));

endmodule

// File: rtl/seq6_counter.sv
module seq6_counter
  import seq6_counter_pkg::*;
(
  input  logic               clk,
  input  logic               syncReset,
  input  logic               enable,
  output logic [STATE_W-1:0] countState,
  output logic               wrapPulse
);

  strobe_t strobes;
  code_t   stateQ;
  logic    wrapQ;

  seq6_counter_ctrl u_ctrl (
    .syncReset (syncReset),
    .enable    (enable),
    .stateQ    (stateQ),
    .strobes   (strobes)
  );

  seq6_counter_dpath u_dpath (
    .clk     (clk),
    .strobes (strobes),
    .stateQ  (stateQ),
    .wrapQ   (wrapQ)
  );

  assign countState = stateQ;
  assign wrapPulse  = wrapQ;

  // R3: hold with enable low keeps a legal code
  assert_hold_R3: assert property (@(posedge clk) disable iff (syncReset)
    (!isUnused(countState) && $past(!syncReset && !enable && !isUnused(countState)))
      |-> (countState == $past(countState)) && !wrapPulse);

  // R7: reset beats enable
  assert_reset_priority_R7: assert property (@(posedge clk)
    (syncReset && enable) |=> (countState == START_CODE));

endmodule

// File: tb/seq6_counter_tb.sv
`timescale 1ns/1ps
module seq6_counter_tb;

  logic       clk = 1'b0;
  logic       rstDrv = 1'b1;
  logic       enDrv = 1'b0;
  logic [2:0] countState;
  logic       wrapPulse;

  int checks = 0;
  int failures = 0;

  // Reference model
  int  loopOrder [6] = '{0, 1, 3, 7, 6, 4};
  int  modelIdx = 0;
  bit  modelWrap = 1'b0;
  bit  injPending = 1'b0;
  bit  lastRst = 1'b1;
  bit  lastEn = 1'b0;
  bit  lastInj = 1'b0;
  logic [2:0] prevState = 3'd0;

  always #2.5 clk = ~clk;

  seq6_counter u_dut (
    .clk        (clk),
    .syncReset  (rstDrv),
    .enable     (enDrv),
    .countState (countState),
    .wrapPulse  (wrapPulse)
  );

  always @(posedge clk) begin
    if (rstDrv) begin
      modelIdx  <= 0;
      modelWrap <= 1'b0;
    end else if (injPending) begin
      modelIdx   <= 0;
      modelWrap  <= 1'b0;
      injPending <= 1'b0;
    end else if (enDrv) begin
      modelWrap <= (modelIdx == 5);
      modelIdx  <= (modelIdx == 5) ? 0 : modelIdx + 1;
    end else begin
      modelWrap <= 1'b0;
    end
  end

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkOutputs();
    string tag;
    if (lastRst && lastEn)  tag = "R7";
    else if (lastRst)       tag = "R1";
    else if (lastInj)       tag = "R6";
    else if (!lastEn)       tag = "R3";
    else                    tag = "R2";
    checkVal({tag, " state"}, int'(countState), loopOrder[modelIdx]);
    checkVal("R4 wrap", int'(wrapPulse), int'(modelWrap));
    checkVal("R8 legal", int'(countState == 3'd2 || countState == 3'd5), 0);
    if (lastEn && !lastRst && !lastInj)
      checkVal("R5 one bit", $countones(countState ^ prevState), 1);
    prevState = countState;
  endtask

  task automatic step(input bit r, input bit e);
    @(negedge clk);
    checkOutputs();
    rstDrv  = r;
    enDrv   = e;
    lastRst = r;
    lastEn  = e;
    lastInj = 1'b0;
  endtask

  task automatic inject(input logic [2:0] code, input bit e);
    @(negedge clk);
    checkOutputs();
    force u_dut.u_dpath.stateQ = code;
    #0.1;
    release u_dut.u_dpath.stateQ;
    checkVal("R6 injected", int'(countState), int'(code));
    injPending = 1'b1;
    rstDrv  = 1'b0;
    enDrv   = e;
    lastRst = 1'b0;
    lastEn  = e;
    lastInj = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    // R2 R4 R5 two full loops
    for (int i = 0; i < 13; i++) step(1'b0, 1'b1);
    // R3 alternating enable
    for (int i = 0; i < 14; i++) step(1'b0, i[0]);
    // R3 long hold
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    // R7 reset with enable in mid loop
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1);
    // R6 recovery from unused codes, starting at 0
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    inject(3'd2, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    inject(3'd5, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule